// File: doc/BRIEF.md
# Serial Transmitter with Fractional Stop Length

This block turns host-written characters into an asynchronous serial stream. It runs from the system clock and advances its bit timing only on cycles where a one-cycle enable, `tick16`, is high. That enable occurs sixteen times per bit period. The host writes a character into a one-entry holding register. When the shifter is idle, the transmitter is enabled and the clear-to-send gate allows it, the character moves into the shifter and goes out on the line.

Each frame has four parts, in this order:
- a low start bit;
- five to eight data bits, least significant first;
- an optional ninth bit, which is computed parity, a forced level, or a multidrop address/data flag;
- a high stop period whose length is set in sixteenths of a bit.

The format is captured when a character starts. Changing the configuration during a frame therefore affects only later frames. Two status outputs tell the host whether the holding register can take a character and whether the line has fully drained. A request-to-send output can be made to drop by itself once everything has been sent.

Top module: `serial_tx_fs`

## Requirements
- R1: `cfg_len` codes 00, 01, 10, 11 select 5, 6, 7, 8 data bits. A frame is one low start bit followed by the data bits, least significant first.
- R2: With `cfg_pmode` = 00, a parity bit follows the data. With `cfg_ptype` = 0 the data bits plus the parity bit hold an even number of ones; with `cfg_ptype` = 1 they hold an odd number.
- R3: With `cfg_pmode` = 01 (forced) or 11 (multidrop), the extra bit equals `cfg_ptype`. With `cfg_pmode` = 10, no extra bit is sent and the stop period follows the last data bit.
- R4: The stop period lasts 9+n ticks for stop code n = 0..7 and 17+n ticks for n = 8..15. When `cfg_len` = 00 and n is 0..7, eight more ticks are added.
- R5: Start, data and extra bits each last exactly 16 `tick16` pulses. The line is high whenever no frame is being sent.
- R6: When `cfg_cts_gate` = 1, no character starts while `cts` is low. When `cfg_cts_gate` = 0, `cts` has no effect.
- R7: After reset: the transmitter is disabled, `txd` = 1, `tx_ready` = 1, `tx_empty` = 1 and `rts` = 0. A write while disabled is discarded.
- R8: A `cmd_tx_en` pulse enables the transmitter and a `cmd_tx_dis` pulse disables it; if both arrive in the same cycle, disable wins. A disable during a frame lets that frame finish with its full stop period.
- R9: `tx_ready` is high exactly when the holding register is empty. `tx_empty` is high when the holding register is empty and the shifter is idle. A character written during a frame starts right after that frame's stop period.
- R10: An `rts_set` pulse raises `rts`. With `cfg_rts_auto` = 1, `rts` falls one cycle after `tx_empty` rises. With `cfg_rts_auto` = 0, `rts` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable pulse, sixteen per bit period |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_pmode | input | 2 | Extra-bit mode: 00 parity, 01 forced, 10 none, 11 multidrop |
| cfg_ptype | input | 1 | Parity sense (0 even, 1 odd), or forced level / address flag |
| cfg_stop | input | 4 | Stop length code |
| cfg_cts_gate | input | 1 | Make character start depend on `cts` |
| cfg_rts_auto | input | 1 | Drop `rts` once the line has drained |
| cmd_tx_en | input | 1 | Enable pulse |
| cmd_tx_dis | input | 1 | Disable pulse |
| rts_set | input | 1 | Pulse that raises `rts` |
| cts | input | 1 | Clear-to-send, high means clear |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both idle |
| rts | output | 1 | Request-to-send |

## Verification
The bench builds the block with its defaults: eight-bit data path and sixteen ticks per bit. With `tick16` held high, one bit is exactly sixteen cycles, so every bit position and every stop tick can be predicted to the cycle. That makes two sweeps practical:
- all 32 combinations of length, extra-bit mode and parity sense;
- all sixteen stop codes, at both the five-bit length and the eight-bit length.

One run with `tick16` at half rate confirms that bit timing counts ticks rather than clock cycles.

// File: rtl/serial_tx_pkg.sv
// Shared types and the stop-length rule for the fractional-stop transmitter.
// Assumes stop lengths are expressed in sixteenths of a bit period.
package serial_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_XBIT  = 3'd3,
        ST_STOP  = 3'd4
    } stx_state_e;

    typedef enum logic [1:0] {
        PM_CALC  = 2'b00,
        PM_FORCE = 2'b01,
        PM_NONE  = 2'b10,
        PM_MDROP = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic [1:0] len;
        par_mode_e  pmode;
        logic       ptype;
        logic [3:0] stop;
    } frame_cfg_t;

    // Stop period in sixteenths of a bit: 9+n below code 8, 17+n from code 8,
    // plus half a bit for five-bit characters on the short codes.
    function automatic logic [5:0] stop_sixteenths(input logic [3:0] code,
                                                   input logic [1:0] len);
        logic [5:0] t;
        if (code[3]) t = 6'd17 + {2'b00, code};
        else         t = 6'd9  + {2'b00, code};
        if (!code[3] && (len == 2'b00)) t = t + 6'd8;
        return t;
    endfunction

endpackage

// File: rtl/stx_hold.sv
// Holding register and transmitter enable state.
// Accepts a write only when enabled and empty. Issues a launch when the
// shifter is idle and the clear-to-send condition (computed by the parent)
// allows it. Assumes command and write inputs are single-cycle pulses.
module stx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shift_idle,
    input  logic              cts_ok,
    output logic              launch,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data
);

    logic enabled;

    // Enable flag: disable has priority over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       enabled <= 1'b0;
        else if (cmd_dis) enabled <= 1'b0;
        else if (cmd_en)  enabled <= 1'b1;
    end

    // Launch condition for the next character.
    always_comb launch = hold_full && enabled && shift_idle && cts_ok;

    // Holding register: emptied by launch, filled by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (launch) begin
            hold_full <= 1'b0;
        end else if (wr_valid && enabled && !hold_full) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end
    end

    a_r7_disabled_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !hold_full) |=> !hold_full);

    a_r8_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dis |=> !enabled);

endmodule

// File: rtl/stx_shift.sv
// Frame shifter: start bit, 5..8 data bits LSB first, optional extra bit,
// then a stop period counted in ticks. Captures the format at launch, so
// configuration changes take effect on the next character only.
// Assumes launch only arrives while idle.
module stx_shift
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              launch,
    input  logic [DATA_W-1:0] data,
    input  frame_cfg_t        cfg,
    output logic              txd,
    output logic              idle
);

    localparam int SUB_W  = $clog2(OVS);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int SCNT_W = $clog2(3 * OVS);

    stx_state_e          state;
    logic [SUB_W-1:0]    sub;
    logic [IDX_W-1:0]    bitn;
    logic [IDX_W-1:0]    last_idx;
    logic [DATA_W-1:0]   sreg;
    logic                xbit;
    logic                has_x;
    logic [SCNT_W-1:0]   scnt;
    logic [SCNT_W-1:0]   stop_len;

    logic [DATA_W-1:0]   data_mask;
    logic                nxt_xbit;
    logic [IDX_W-1:0]    nxt_last;
    logic [SCNT_W-1:0]   nxt_stop;
    logic                sub_end;

    // Launch-time values derived from the configuration.
    always_comb begin
        data_mask = {DATA_W{1'b1}} >> (2'd3 - cfg.len);
        nxt_xbit  = (cfg.pmode == PM_CALC) ? ((^(data & data_mask)) ^ cfg.ptype)
                                           : cfg.ptype;
        nxt_last  = IDX_W'(3'd4 + {1'b0, cfg.len});
        nxt_stop  = SCNT_W'((int'(stop_sixteenths(cfg.stop, cfg.len)) * OVS) / 16);
    end

    // End of one bit period: last tick of the sixteen.
    always_comb sub_end = tick && (sub == SUB_W'(OVS - 1));

    always_comb idle = (state == ST_IDLE);

    // Frame sequencer and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            txd      <= 1'b1;
            sub      <= '0;
            bitn     <= '0;
            last_idx <= '0;
            sreg     <= '0;
            xbit     <= 1'b0;
            has_x    <= 1'b0;
            scnt     <= '0;
            stop_len <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        state    <= ST_START;
                        txd      <= 1'b0;
                        sub      <= '0;
                        sreg     <= data;
                        xbit     <= nxt_xbit;
                        has_x    <= (cfg.pmode != PM_NONE);
                        last_idx <= nxt_last;
                        stop_len <= nxt_stop;
                    end
                end
                ST_START: begin
                    if (sub_end) begin
                        state <= ST_DATA;
                        txd   <= sreg[0];
                        sreg  <= sreg >> 1;
                        bitn  <= '0;
                        sub   <= '0;
                    end else if (tick) begin
                        sub <= sub + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (sub_end) begin
                        sub <= '0;
                        if (bitn == last_idx) begin
                            if (has_x) begin
                                state <= ST_XBIT;
                                txd   <= xbit;
                            end else begin
                                state <= ST_STOP;
                                txd   <= 1'b1;
                                scnt  <= '0;
                            end
                        end else begin
                            txd  <= sreg[0];
                            sreg <= sreg >> 1;
                            bitn <= bitn + 1'b1;
                        end
                    end else if (tick) begin
                        sub <= sub + 1'b1;
                    end
                end
                ST_XBIT: begin
                    if (sub_end) begin
                        state <= ST_STOP;
                        txd   <= 1'b1;
                        scnt  <= '0;
                        sub   <= '0;
                    end else if (tick) begin
                        sub <= sub + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (scnt == stop_len - 1'b1) state <= ST_IDLE;
                        else                         scnt  <= scnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    txd   <= 1'b1;
                end
            endcase
        end
    end

    a_r5_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> txd);

    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> !txd);

    a_r1_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bitn <= last_idx));

    a_r4_stop_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> (scnt < stop_len));

endmodule

// File: rtl/stx_rts.sv
// Request-to-send control: raised by a host pulse, optionally dropped on
// the cycle after the transmitter becomes fully empty.
module stx_rts (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_set,
    input  logic auto_en,
    input  logic tx_empty,
    output logic rts
);

    logic empty_q;

    // Previous-cycle empty flag for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) empty_q <= 1'b1;
        else        empty_q <= tx_empty;
    end

    // RTS register: set wins over the automatic drop.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rts <= 1'b0;
        else if (rts_set)                            rts <= 1'b1;
        else if (auto_en && tx_empty && !empty_q)    rts <= 1'b0;
    end

    a_r10_drop_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> tx_empty);

    a_r10_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rts && !tx_empty) |=> rts);

endmodule

// File: rtl/serial_tx_fs.sv
// Top level of the fractional-stop serial transmitter. Joins the holding
// register, the frame shifter and the RTS control, and applies the CTS gate.
// Assumes tick16 is a one-cycle enable, sixteen per bit period.
module serial_tx_fs
    import serial_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_pmode,
    input  logic              cfg_ptype,
    input  logic [3:0]        cfg_stop,
    input  logic              cfg_cts_gate,
    input  logic              cfg_rts_auto,
    input  logic              cmd_tx_en,
    input  logic              cmd_tx_dis,
    input  logic              rts_set,
    input  logic              cts,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              rts
);

    frame_cfg_t        cfg;
    logic              cts_ok;
    logic              launch;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              shift_idle;

    // Pack the format inputs and evaluate the clear-to-send gate.
    always_comb begin
        cfg.len   = cfg_len;
        cfg.pmode = par_mode_e'(cfg_pmode);
        cfg.ptype = cfg_ptype;
        cfg.stop  = cfg_stop;
        cts_ok    = !cfg_cts_gate || cts;
    end

    stx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_en     (cmd_tx_en),
        .cmd_dis    (cmd_tx_dis),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .shift_idle (shift_idle),
        .cts_ok     (cts_ok),
        .launch     (launch),
        .hold_full  (hold_full),
        .hold_data  (hold_data)
    );

    stx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .launch (launch),
        .data   (hold_data),
        .cfg    (cfg),
        .txd    (txd),
        .idle   (shift_idle)
    );

    // Status flags seen by the host.
    always_comb begin
        tx_ready = !hold_full;
        tx_empty = !hold_full && shift_idle;
    end

    stx_rts u_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .rts_set  (rts_set),
        .auto_en  (cfg_rts_auto),
        .tx_empty (tx_empty),
        .rts      (rts)
    );

    a_r6_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!cfg_cts_gate || cts));

    a_r9_empty_means_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

endmodule

// File: tb/serial_tx_fs_tb.sv
module serial_tx_fs_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       tick_slow = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_pmode = 2'd2;
    logic       cfg_ptype = 1'b0;
    logic [3:0] cfg_stop = 4'd7;
    logic       cfg_cts_gate = 1'b0;
    logic       cfg_rts_auto = 1'b0;
    logic       cmd_tx_en = 1'b0;
    logic       cmd_tx_dis = 1'b0;
    logic       rts_set = 1'b0;
    logic       cts = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_ready, tx_empty, rts;

    int checks = 0;
    int fails  = 0;

    serial_tx_fs u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cfg_len(cfg_len), .cfg_pmode(cfg_pmode), .cfg_ptype(cfg_ptype),
        .cfg_stop(cfg_stop), .cfg_cts_gate(cfg_cts_gate), .cfg_rts_auto(cfg_rts_auto),
        .cmd_tx_en(cmd_tx_en), .cmd_tx_dis(cmd_tx_dis), .rts_set(rts_set),
        .cts(cts), .wr_valid(wr_valid), .wr_data(wr_data),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .rts(rts)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) tick16 <= tick_slow ? ~tick16 : 1'b1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int stop_exp(input int code, input int len);
        int t = (code < 8) ? 9 + code : 17 + code;
        if (code < 8 && len == 0) t += 8;
        return t;
    endfunction

    task automatic pulse_en();
        cmd_tx_en = 1'b1; @(negedge clk); cmd_tx_en = 1'b0;
    endtask

    task automatic write(input logic [7:0] d);
        int g = 0;
        while (!tx_ready && g < 5000) begin @(negedge clk); g++; end
        wr_data = d; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Observe one frame and its stop period; dis_bit selects a bit index
    // at which a disable pulse is issued (negative for none).
    task automatic check_frame(input logic [7:0] d, input int len, input int pm,
                               input bit pt, input int exp_stop, input int dis_bit,
                               input string tag);
        int g = 0;
        int nb = 5 + len;
        int np = (pm == 2) ? 0 : 1;
        int total = 1 + nb + np;
        logic [11:0] exp_v = '0;
        logic [11:0] obs_v = '0;
        logic [7:0] m = 8'((1 << nb) - 1);
        int n = 0;
        while (txd !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
        chk(g < 5000, {tag, " start seen"}, g, 0);
        for (int i = 0; i < nb; i++) exp_v[1+i] = d[i];
        if (np == 1) exp_v[1+nb] = (pm == 0) ? ((^(d & m)) ^ pt) : pt;
        repeat (7) @(negedge clk);
        obs_v[0] = txd;
        for (int b = 1; b < total; b++) begin
            if (b == dis_bit) cmd_tx_dis = 1'b1;
            for (int k = 0; k < 16; k++) begin @(negedge clk); cmd_tx_dis = 1'b0; end
            obs_v[b] = txd;
        end
        chk(obs_v == exp_v, {tag, " frame bits"}, int'(obs_v), int'(exp_v));
        repeat (9) @(negedge clk);
        chk(txd == 1'b1, {tag, " stop high"}, int'(txd), 1);
        while (!tx_empty && txd == 1'b1 && n < 300) begin @(negedge clk); n++; end
        chk(n == exp_stop, {tag, " R4 stop ticks"}, n, exp_stop);
    endtask

    initial begin
        #(CLK_P * 190000);
        fails++; checks++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk(txd == 1 && tx_ready == 1 && tx_empty == 1 && rts == 0,
            "R7 reset outputs", {txd, tx_ready, tx_empty, rts}, 4'b1110);
        // R7 write while disabled is discarded
        write(8'hA5);
        repeat (40) @(negedge clk);
        chk(tx_empty == 1 && txd == 1, "R7 disabled write ignored", {tx_empty, txd}, 2'b11);
        pulse_en();

        // R1 R2 R3 sweep over length, mode and sense
        for (int len = 0; len < 4; len++)
            for (int pm = 0; pm < 4; pm++)
                for (int pt = 0; pt < 2; pt++) begin
                    logic [7:0] d = 8'(len * 71 + pm * 29 + pt * 13 + 3);
                    cfg_len = 2'(len); cfg_pmode = 2'(pm); cfg_ptype = pt[0]; cfg_stop = 4'd7;
                    write(d);
                    check_frame(d, len, pm, pt[0], stop_exp(7, len), -1, "R1 R2 R3 sweep");
                end

        // R4 stop code sweep at 5 and 8 bits
        for (int sc = 0; sc < 16; sc++)
            for (int li = 0; li < 2; li++) begin
                int len = li * 3;
                logic [7:0] d = 8'(sc * 37 + 5);
                cfg_len = 2'(len); cfg_pmode = 2'd2; cfg_stop = 4'(sc);
                write(d);
                check_frame(d, len, 2, 1'b0, stop_exp(sc, len), -1, "R4 sweep");
            end

        // R5 bit time follows tick16 at half rate
        begin
            int g = 0;
            int hi = 0;
            cfg_len = 2'd3; cfg_pmode = 2'd2; cfg_stop = 4'd7;
            tick_slow = 1'b1;
            write(8'h55);
            while (txd !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
            while (txd !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
            while (txd === 1'b1 && hi < 200) begin @(negedge clk); hi++; end
            chk(hi == 32, "R5 bit length at half tick rate", hi, 32);
            g = 0;
            while (!tx_empty && g < 5000) begin @(negedge clk); g++; end
            tick_slow = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R6 CTS gate holds the character back
        cfg_cts_gate = 1'b1; cts = 1'b0;
        write(8'h3C);
        repeat (60) @(negedge clk);
        chk(txd == 1 && tx_empty == 0 && tx_ready == 0, "R6 blocked by cts",
            {txd, tx_empty, tx_ready}, 3'b100);
        cts = 1'b1;
        check_frame(8'h3C, 3, 2, 1'b0, stop_exp(7, 3), -1, "R6 released");
        cfg_cts_gate = 1'b0; cts = 1'b0;
        write(8'hC3);
        check_frame(8'hC3, 3, 2, 1'b0, stop_exp(7, 3), -1, "R6 gate off");
        cts = 1'b1;

        // R9 second character waits in the holding register
        cfg_stop = 4'd2;
        write(8'h81);
        write(8'h7E);
        chk(tx_ready == 0 && tx_empty == 0, "R9 holding full during frame",
            {tx_ready, tx_empty}, 2'b00);
        check_frame(8'h81, 3, 2, 1'b0, stop_exp(2, 3), -1, "R9 first");
        check_frame(8'h7E, 3, 2, 1'b0, stop_exp(2, 3), -1, "R9 second");
        chk(tx_ready == 1 && tx_empty == 1, "R9 drained", {tx_ready, tx_empty}, 2'b11);

        // R8 disable mid-frame lets the frame finish, then writes are dropped
        cfg_pmode = 2'd0; cfg_ptype = 1'b1;
        write(8'h96);
        check_frame(8'h96, 3, 0, 1'b1, stop_exp(2, 3), 3, "R8 disable mid-frame");
        write(8'h11);
        repeat (50) @(negedge clk);
        chk(tx_empty == 1 && txd == 1, "R8 disabled after frame", {tx_empty, txd}, 2'b11);
        pulse_en();
        write(8'h22);
        check_frame(8'h22, 3, 0, 1'b1, stop_exp(2, 3), -1, "R8 re-enabled");
        // R8 both commands together: disable wins
        cmd_tx_en = 1'b1; cmd_tx_dis = 1'b1;
        @(negedge clk);
        cmd_tx_en = 1'b0; cmd_tx_dis = 1'b0;
        write(8'h44);
        repeat (50) @(negedge clk);
        chk(tx_empty == 1 && txd == 1, "R8 disable wins", {tx_empty, txd}, 2'b11);
        pulse_en();

        // R10 automatic RTS drop
        cfg_pmode = 2'd2; cfg_rts_auto = 1'b1;
        rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
        chk(rts == 1, "R10 rts raised", int'(rts), 1);
        write(8'h5A);
        check_frame(8'h5A, 3, 2, 1'b0, stop_exp(2, 3), -1, "R10 frame");
        chk(rts == 1, "R10 rts held until drain", int'(rts), 1);
        @(negedge clk);
        chk(rts == 0, "R10 rts dropped after empty", int'(rts), 0);
        cfg_rts_auto = 1'b0;
        rts_set = 1'b1; @(negedge clk); rts_set = 1'b0;
        write(8'hA0);
        check_frame(8'hA0, 3, 2, 1'b0, stop_exp(2, 3), -1, "R10 manual");
        repeat (3) @(negedge clk);
        chk(rts == 1, "R10 rts kept without auto", int'(rts), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule